// File: doc/BRIEF.md
# Trimmed Periodic Interrupt Timer

This block produces a periodic timeout from the system clock. A short prescaler turns the clock into slow ticks. Its length is 64 clock cycles, and a six-bit trim value moves that length up or down. A 16-bit rate value then counts ticks down, so one timeout happens every rate+1 ticks. Each timeout sets a sticky flag. The interrupt line is that flag gated by an enable bit.

Software sees four byte registers on a simple synchronous bus: control, trim, rate high byte and rate low byte. The timer starts counting when the run bit goes from 0 to 1. Software takes the flag down by writing a 1 to its bit. If a clear and a timeout meet in the same cycle, the clear wins. A new rate value is used only at the next reload of the period counter. A change of trim takes effect within the tick that is running.

Top module: `apit_timer`

## Requirements
- R1: After reset all four registers read 0, `irq` is 0 and the timer is stopped.
- R2: The control register (address 0) holds enable in bit 0, the flag in bit 1 and run in bit 2, and `irq` is high exactly when both flag and enable are 1.
- R3: The flag becomes 1 at every timeout and stays 1 until a control write with bit 1 set; a control write with bit 1 at 0 leaves the flag unchanged.
- R4: When a flag-clearing write lands on the same clock edge as a timeout, the flag is 0 afterwards.
- R5: The trim register (address 1) stores the trim value in bits 7:2; bits 1:0 always read 0.
- R6: One tick lasts 64 + 32·T5 − 16·T4 − 8·T3 − 4·T2 − 2·T1 − T0 clock cycles, where Tn is trim bit n (register bit n+2), giving 33 to 96 cycles.
- R7: While running, timeouts come every (rate+1) ticks, where rate is {address 2, address 3} (high byte, low byte).
- R8: A control write that turns run from 0 to 1 restarts the prescaler and loads the period counter from rate; the flag is then set (rate+1)·tick + 1 cycles after the write's clock edge.
- R9: A rate write made while running does not change the period in progress; it is used from the next reload.
- R10: While run is 0 no timeout occurs and the flag does not change by itself.
- R11: Read data is a combinational function of the address: 0 control, 1 trim, 2 rate high, 3 rate low, and every written rate byte reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
The bench uses the default parameters: a 64-cycle nominal tick, six trim bits and a 16-bit rate. With these, every trim extreme from 33 to 96 cycles fits in a run of a few hundred cycles. A rate with the high byte set (256) takes about 8,500 cycles, so the high byte is covered as well. The bench knows the timeout edges exactly, so it can place a clear write on the very edge of a timeout to check the precedence rule. It also changes the rate in the middle of a period to show that the new value waits for the next reload.

// File: rtl/apit_pkg.sv
package apit_pkg;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_TRIM    = 2'd1,
    REG_RATE_HI = 2'd2,
    REG_RATE_LO = 2'd3
  } apit_reg_e;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_FLAG = 1;
  localparam int CTRL_RUN  = 2;
  localparam int BYTE_W    = 8;

endpackage

// File: rtl/apit_prescaler.sv
module apit_prescaler
  import apit_pkg::*;
#(
  parameter int NOMINAL_TICKS = 64,
  parameter int TRIM_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [TRIM_W-1:0] trim,
  output logic              tick
);

  localparam int MAX_LEN = NOMINAL_TICKS + NOMINAL_TICKS / 2;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] last_idx;

  // Top trim bit adds half the nominal length; each lower bit k subtracts
  // nominal >> (TRIM_W-k), so every weight is half the one above it.
  always_comb begin
    int len;
    len = NOMINAL_TICKS;
    for (int k = 0; k < TRIM_W; k++) begin
      if (trim[k]) begin
        if (k == TRIM_W - 1) len = len + (NOMINAL_TICKS >> 1);
        else                 len = len - (NOMINAL_TICKS >> (TRIM_W - k));
      end
    end
    last_idx = LEN_W'(len - 1);
  end

  // A trim change mid-tick that shortens the length below the count ends
  // the tick at once instead of wrapping the counter.
  assign tick = run && !restart && (cnt_q >= last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || restart || tick) cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R6

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/apit_rate_counter.sv
module apit_rate_counter #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  output logic              restart,
  output logic              timeout
);

  logic              run_d;
  logic [RATE_W-1:0] cnt_q;

  assign restart = run && !run_d;
  assign timeout = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_d <= run;
      if (restart)          cnt_q <= rate;
      else if (timeout)     cnt_q <= rate;
      else if (tick)        cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_RELOAD_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (cnt_q == $past(rate))); // R7

  AST_RELOAD_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(rate))); // R8

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/apit_regs.sv
module apit_regs
  import apit_pkg::*;
#(
  parameter int TRIM_W = 6,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              timeout,
  output logic              en,
  output logic              flag,
  output logic              run,
  output logic [TRIM_W-1:0] trim,
  output logic [RATE_W-1:0] rate
);

  localparam int TRIM_LSB = BYTE_W - TRIM_W;

  logic ctrl_wr, trim_wr, hi_wr, lo_wr, clr;

  assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
  assign trim_wr = bus_we && (bus_addr == REG_TRIM);
  assign hi_wr   = bus_we && (bus_addr == REG_RATE_HI);
  assign lo_wr   = bus_we && (bus_addr == REG_RATE_LO);
  assign clr     = ctrl_wr && bus_wdata[CTRL_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      run  <= 1'b0;
      flag <= 1'b0;
      trim <= '0;
      rate <= '0;
    end else begin
      if (ctrl_wr) begin
        en  <= bus_wdata[CTRL_EN];
        run <= bus_wdata[CTRL_RUN];
      end
      if (clr)          flag <= 1'b0;
      else if (timeout) flag <= 1'b1;
      if (trim_wr) trim <= bus_wdata[BYTE_W-1:TRIM_LSB];
      if (hi_wr)   rate[RATE_W-1 -: BYTE_W] <= bus_wdata;
      if (lo_wr)   rate[BYTE_W-1:0]         <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_CTRL: begin
        bus_rdata[CTRL_EN]   = en;
        bus_rdata[CTRL_FLAG] = flag;
        bus_rdata[CTRL_RUN]  = run;
      end
      REG_TRIM:    bus_rdata[BYTE_W-1:TRIM_LSB] = trim;
      REG_RATE_HI: bus_rdata = rate[RATE_W-1 -: BYTE_W];
      default:     bus_rdata = rate[BYTE_W-1:0];
    endcase
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R3

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !clr) |=> flag); // R3

  AST_TRIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_wr |=> $stable(trim)); // R5

endmodule

// File: rtl/apit_timer.sv
module apit_timer
  import apit_pkg::*;
#(
  parameter int NOMINAL_TICKS = 64,
  parameter int TRIM_W        = 6,
  parameter int RATE_W        = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq
);

  logic              en, flag, run, tick, restart, timeout;
  logic [TRIM_W-1:0] trim;
  logic [RATE_W-1:0] rate;

  apit_regs #(.TRIM_W(TRIM_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .timeout(timeout),
    .en(en), .flag(flag), .run(run), .trim(trim), .rate(rate)
  );

  apit_prescaler #(.NOMINAL_TICKS(NOMINAL_TICKS), .TRIM_W(TRIM_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .trim(trim), .tick(tick)
  );

  apit_rate_counter #(.RATE_W(RATE_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .rate(rate),
    .restart(restart), .timeout(timeout)
  );

  assign irq = flag && en;

  AST_NO_TIMEOUT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !timeout); // R10

endmodule

// File: tb/apit_timer_bench.sv
module apit_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  apit_timer u_apit_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // trim value (6 bits), rate, full timeout period in clock cycles
  localparam int VEC [7][3] = '{
    '{6'h00,   0,   64},
    '{6'h20,   1,  192},
    '{6'h1F,   2,   99},
    '{6'h3F,   0,   65},
    '{6'h10,   3,  192},
    '{6'h01,   1,  126},
    '{6'h1F, 256, 8481}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_irq(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!irq && c < 20000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk($sformatf("R1 reset read addr %0d", a), v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);

    // Vector table: R6 R7 R8 R11
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, 8'h00);
      wr(2'd0, 8'h02);
      wr(2'd1, 8'(VEC[i][0] << 2));
      wr(2'd2, 8'(VEC[i][1] >> 8));
      wr(2'd3, 8'(VEC[i][1]));
      rd(2'd1, v); chk($sformatf("R5 trim readback vec %0d", i), v, (VEC[i][0] << 2) & 8'hFC);
      rd(2'd2, v); chk($sformatf("R11 rate hi vec %0d", i), v, (VEC[i][1] >> 8) & 8'hFF);
      rd(2'd3, v); chk($sformatf("R11 rate lo vec %0d", i), v, VEC[i][1] & 8'hFF);
      wr(2'd0, 8'h05);
      wait_irq(c);
      chk($sformatf("R8 R6 first timeout vec %0d", i), c, VEC[i][2] + 1);
      wr(2'd0, 8'h07);
      wait_irq(c);
      chk($sformatf("R7 steady period vec %0d", i), c, VEC[i][2] - 1);
    end

    // R5: reserved trim bits read 0
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h02);
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    chk("R5 reserved bits", v, 8'hFC);

    // R2/R3/R10: enable gating, write-zero, clear, stopped timer
    wr(2'd1, 8'h7C);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h04);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk("R2 flag set, enable off", v, 8'h06);
    chk("R2 irq gated off", int'(irq), 0);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R3 write 0 keeps flag", v, 8'h02);
    wr(2'd0, 8'h01);
    chk("R2 irq with enable", int'(irq), 1);
    wr(2'd0, 8'h03);
    rd(2'd0, v); chk("R3 clear by writing 1", v, 8'h01);
    chk("R3 irq after clear", int'(irq), 0);
    repeat (300) @(negedge clk);
    rd(2'd0, v); chk("R10 stopped no timeout", v, 8'h01);

    // R4: clear lands on timeout edge (tick 33 cycles, rate 0)
    wr(2'd0, 8'h05);
    repeat (66) @(negedge clk);
    rd(2'd0, v); chk("R4 flag set before collision", v, 8'h07);
    wr(2'd0, 8'h07);
    rd(2'd0, v); chk("R4 clear beats timeout", v, 8'h05);
    wait_irq(c);
    chk("R4 period unchanged after collision", c, 33);

    // R9: rate written mid-run takes effect at next reload
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h07);
    wait_irq(c);
    chk("R9 old rate still in use", c, 31);
    wr(2'd0, 8'h07);
    wait_irq(c);
    chk("R9 new rate after reload", c, 65);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule